// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a 1024-word by 8-bit storage array with two fully independent access ports, called left and right. Each port has its own active-low select, active-low write strobe, active-low read enable, address and write data. Both ports run on one shared clock. All strobes are sampled on the rising edge. Read data is returned one clock after the access, together with a valid flag. When that flag is low the data bus reads zero, so the port needs no high-impedance state.

The two highest addresses double as mailboxes for passing messages between the ports. When the right port writes the second-highest word, a flag toward the left port is raised. When the left port writes the highest word, a flag toward the right port is raised. The receiving port clears its flag by accessing its own mailbox address with select and read enable low. Both mailbox words are still ordinary storage.

Each port also has an active-low blocking input. A collision arbiter outside this block drives it. While it is low, that port's writes are dropped and its flag actions are dropped, but its reads still take place.

Top module: `dpram_mailbox`

## Requirements
- R1: With select low, write strobe low and the block input high, the port stores its write data at its address. A later read of that address from either port returns the stored value.
- R2: With select low, read enable low and write strobe high, the port's read data equals the addressed word one clock later, with read-valid high. In any other cycle read-valid is low and the read data is zero.
- R3: A right-port write to address 0x3FE drives the left interrupt output low (active low) from the next clock.
- R4: A left-port access to 0x3FE with select and read enable low clears the left interrupt from the next clock. This holds whatever the level of the write strobe.
- R5: A left-port write to 0x3FF drives the right interrupt output low from the next clock. A right-port access to 0x3FF with select and read enable low clears it.
- R6: The words at 0x3FE and 0x3FF store and return data like any other address.
- R7: While a port's block input is low, a write from that port leaves memory unchanged. Any interrupt set or clear that this port would cause does not happen.
- R8: With select high, a port neither reads nor writes, and its read-valid stays low.
- R9: After reset both interrupt outputs are high and both read-valid outputs are low.
- R10: If one interrupt flag is set and cleared in the same cycle, the set wins and the interrupt stays asserted.
- R11: If both ports write the same address in the same cycle, the left port's data is stored.
- R12: A read in the same cycle as a write to the same address by the other port returns the word's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_blk_n | input | 1 | Left write block, active low |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_blk_n | input | 1 | Right write block, active low |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result of this block is due exactly one rising edge after the strobes that cause it are sampled. This covers read data, read-valid, and the setting or clearing of an interrupt. A write shows up on the next read that is sampled after its edge. The bench drives each access just after an edge and waits for the next rising edge. It samples 1 ns after that edge, then returns the ports to idle. In this way every check looks at the output produced by one access alone. Same-cycle cases drive both ports in the same window, so that both sides meet at one edge. These cases are the collision, the set-against-clear, and the read against a write.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
   localparam int unsigned DPM_AW_DEFAULT = 10;
   localparam int unsigned DPM_DW_DEFAULT = 8;

   // decoded intent of one port for the current cycle
   typedef struct packed {
      logic we;   // gated write
      logic rd;   // read returning data
      logic ack;  // read-enabled access usable for mailbox clear
   } dpm_dec_t;
endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec
   import dpm_pkg::*;
#(
   parameter int unsigned AW = DPM_AW_DEFAULT
) (
   input  logic          sel_n,
   input  logic          wr_n,
   input  logic          oe_n,
   input  logic          blk_n,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] own_box,
   input  logic [AW-1:0] far_box,
   output dpm_dec_t      dec,
   output logic          set_far,
   output logic          clr_own
);
   always_comb begin
      dec.we  = !sel_n && !wr_n && blk_n;
      dec.rd  = !sel_n && !oe_n && wr_n;
      dec.ack = !sel_n && !oe_n && blk_n;
      set_far = dec.we && (addr == far_box);
      clr_own = dec.ack && (addr == own_box);
   end
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R10
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R4
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(flag_o)); // R7
endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_l,
   input  logic          rd_l,
   input  logic [AW-1:0] a_l,
   input  logic [DW-1:0] d_l,
   input  logic          we_r,
   input  logic          rd_r,
   input  logic [AW-1:0] a_r,
   input  logic [DW-1:0] d_r,
   output logic [DW-1:0] q_l,
   output logic          v_l,
   output logic [DW-1:0] q_r,
   output logic          v_r
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // right first, left last: left wins a same-address collision
   always_ff @(posedge clk) begin
      if (we_r) mem[a_r] <= d_r;
      if (we_l) mem[a_l] <= d_l;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_l <= '0;
         v_l <= 1'b0;
         q_r <= '0;
         v_r <= 1'b0;
      end else begin
         q_l <= rd_l ? mem[a_l] : '0;
         v_l <= rd_l;
         q_r <= rd_r ? mem[a_r] : '0;
         v_r <= rd_r;
      end
   end

   AST_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (we_l && we_r && (a_l == a_r)) |=> (mem[$past(a_l)] == $past(d_l))); // R11
   AST_RVALID_L: assert property (@(posedge clk) disable iff (!rst_n)
      rd_l |=> v_l); // R2
   AST_RVALID_R: assert property (@(posedge clk) disable iff (!rst_n)
      rd_r |=> v_r); // R2
   AST_NO_STRAY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_l |=> (!v_l && q_l == '0)); // R8
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
   import dpm_pkg::*;
#(
   parameter int unsigned AW      = DPM_AW_DEFAULT,
   parameter int unsigned DW      = DPM_DW_DEFAULT,
   parameter bit          MBOX_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_sel_n,
   input  logic          l_wr_n,
   input  logic          l_oe_n,
   input  logic          l_blk_n,
   input  logic [AW-1:0] l_addr,
   input  logic [DW-1:0] l_wdata,
   output logic [DW-1:0] l_rdata,
   output logic          l_rvalid,
   output logic          l_irq_n,
   input  logic          r_sel_n,
   input  logic          r_wr_n,
   input  logic          r_oe_n,
   input  logic          r_blk_n,
   input  logic [AW-1:0] r_addr,
   input  logic [DW-1:0] r_wdata,
   output logic [DW-1:0] r_rdata,
   output logic          r_rvalid,
   output logic          r_irq_n
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam logic [AW-1:0] BOX_L = AW'(DEPTH - 2);  // read by left
   localparam logic [AW-1:0] BOX_R = AW'(DEPTH - 1);  // read by right

   generate
      if (AW < 2) begin : g_bad_aw
         $error("dpram_mailbox: AW must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dpram_mailbox: DW must be at least 1");
      end
   endgenerate

   dpm_dec_t dec_l, dec_r;
   logic     set_to_r, clr_l, set_to_l, clr_r;
   logic     flag_l, flag_r;

   dpm_port_dec #(.AW(AW)) u_dec_l (
      .sel_n(l_sel_n), .wr_n(l_wr_n), .oe_n(l_oe_n), .blk_n(l_blk_n),
      .addr(l_addr), .own_box(BOX_L), .far_box(BOX_R),
      .dec(dec_l), .set_far(set_to_r), .clr_own(clr_l));

   dpm_port_dec #(.AW(AW)) u_dec_r (
      .sel_n(r_sel_n), .wr_n(r_wr_n), .oe_n(r_oe_n), .blk_n(r_blk_n),
      .addr(r_addr), .own_box(BOX_R), .far_box(BOX_L),
      .dec(dec_r), .set_far(set_to_l), .clr_own(clr_r));

   dpm_array #(.AW(AW), .DW(DW)) u_array (
      .clk(clk), .rst_n(rst_n),
      .we_l(dec_l.we), .rd_l(dec_l.rd), .a_l(l_addr), .d_l(l_wdata),
      .we_r(dec_r.we), .rd_r(dec_r.rd), .a_r(r_addr), .d_r(r_wdata),
      .q_l(l_rdata), .v_l(l_rvalid), .q_r(r_rdata), .v_r(r_rvalid));

   generate
      if (MBOX_EN) begin : g_mbox
         dpm_irq_flag u_flag_l (.clk(clk), .rst_n(rst_n),
            .set_i(set_to_l), .clr_i(clr_l), .flag_o(flag_l));
         dpm_irq_flag u_flag_r (.clk(clk), .rst_n(rst_n),
            .set_i(set_to_r), .clr_i(clr_r), .flag_o(flag_r));
      end else begin : g_no_mbox
         assign flag_l = 1'b0;
         assign flag_r = 1'b0;
      end
   endgenerate

   assign l_irq_n = !flag_l;
   assign r_irq_n = !flag_r;

   AST_LEFT_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_sel_n && !r_wr_n && r_blk_n && r_addr == BOX_L) |=> !l_irq_n); // R3
   AST_RIGHT_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel_n && !l_wr_n && l_blk_n && l_addr == BOX_R) |=> !r_irq_n); // R5
   AST_DESELECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      r_sel_n |=> !r_rvalid); // R8
   AST_BLOCKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_blk_n && r_irq_n && (r_sel_n || r_oe_n || r_addr != BOX_R)) |=> r_irq_n); // R7
endmodule

// File: tb/sim_dpram_mailbox.sv
`timescale 1ns/1ps
module sim_dpram_mailbox;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_sel_n, l_wr_n, l_oe_n, l_blk_n;
   logic [9:0] l_addr;
   logic [7:0] l_wdata;
   logic [7:0] l_rdata;
   logic       l_rvalid, l_irq_n;
   logic       r_sel_n, r_wr_n, r_oe_n, r_blk_n;
   logic [9:0] r_addr;
   logic [7:0] r_wdata;
   logic [7:0] r_rdata;
   logic       r_rvalid, r_irq_n;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   dpram_mailbox u0 (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_blk_n(l_blk_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .l_rvalid(l_rvalid), .l_irq_n(l_irq_n),
      .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_blk_n(r_blk_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .r_rvalid(r_rvalid), .r_irq_n(r_irq_n));

   // {addr, data}
   localparam logic [17:0] VEC [8] = '{
      {10'h000, 8'h01}, {10'h001, 8'hFE}, {10'h155, 8'hA5}, {10'h2AA, 8'h5A},
      {10'h0FF, 8'h80}, {10'h3FD, 8'h7F}, {10'h040, 8'h12}, {10'h020, 8'h00}};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      l_sel_n = 1; l_wr_n = 1; l_oe_n = 1; l_blk_n = 1; l_addr = '0; l_wdata = '0;
      r_sel_n = 1; r_wr_n = 1; r_oe_n = 1; r_blk_n = 1; r_addr = '0; r_wdata = '0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic lwr(input logic [9:0] a, input logic [7:0] d);
      l_sel_n = 0; l_wr_n = 0; l_addr = a; l_wdata = d;
   endtask
   task automatic rwr(input logic [9:0] a, input logic [7:0] d);
      r_sel_n = 0; r_wr_n = 0; r_addr = a; r_wdata = d;
   endtask
   task automatic lrd(input logic [9:0] a);
      l_sel_n = 0; l_oe_n = 0; l_addr = a;
   endtask
   task automatic rrd(input logic [9:0] a);
      r_sel_n = 0; r_oe_n = 0; r_addr = a;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle();
      repeat (3) step();
      chk(l_irq_n && r_irq_n, "R9", {l_irq_n, r_irq_n}, 2'b11);
      chk(!l_rvalid && !r_rvalid, "R9", {l_rvalid, r_rvalid}, 2'b00);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < 8; i++) begin
         lwr(VEC[i][17:8], VEC[i][7:0]); step(); idle();
         rrd(VEC[i][17:8]); step();
         chk(r_rvalid && r_rdata == VEC[i][7:0], "R1/R2", r_rdata, VEC[i][7:0]);
         idle();
      end
      step();
      chk(!l_rvalid && l_rdata == 8'h00, "R2", {l_rvalid, l_rdata}, 0);

      // R8: deselected port ignores read and write
      r_sel_n = 1; r_oe_n = 0; r_addr = 10'h155; step();
      chk(!r_rvalid && r_rdata == 8'h00, "R8", {r_rvalid, r_rdata}, 0);
      idle();
      l_sel_n = 1; l_wr_n = 0; l_addr = 10'h155; l_wdata = 8'hFF; step(); idle();
      lrd(10'h155); step();
      chk(l_rdata == 8'hA5, "R8", l_rdata, 8'hA5); idle();

      // R3 / R4 / R6
      rwr(10'h3FE, 8'h5A); step();
      chk(!l_irq_n && r_irq_n, "R3", {l_irq_n, r_irq_n}, 2'b01); idle();
      lrd(10'h3FE); step();
      chk(l_irq_n, "R4", l_irq_n, 1);
      chk(l_rdata == 8'h5A && l_rvalid, "R6", l_rdata, 8'h5A); idle();
      rwr(10'h3FE, 8'h33); step(); idle();
      chk(!l_irq_n, "R3", l_irq_n, 0);
      l_sel_n = 0; l_oe_n = 0; l_wr_n = 0; l_addr = 10'h3FE; l_wdata = 8'h11; step();
      chk(l_irq_n, "R4", l_irq_n, 1); idle();
      rrd(10'h3FE); step();
      chk(r_rdata == 8'h11, "R6", r_rdata, 8'h11); idle();

      // R5
      lwr(10'h3FF, 8'hC3); step();
      chk(!r_irq_n && l_irq_n, "R5", {l_irq_n, r_irq_n}, 2'b10); idle();
      rrd(10'h3FF); step();
      chk(r_irq_n, "R5", r_irq_n, 1);
      chk(r_rdata == 8'hC3, "R6", r_rdata, 8'hC3); idle();

      // R7: blocked write changes nothing
      lwr(10'h3FF, 8'h77); l_blk_n = 0; step();
      chk(r_irq_n, "R7", r_irq_n, 1); idle();
      rrd(10'h3FF); step();
      chk(r_rdata == 8'hC3, "R7", r_rdata, 8'hC3); idle();
      rwr(10'h3FE, 8'h44); step(); idle();
      lrd(10'h3FE); l_blk_n = 0; step();
      chk(!l_irq_n, "R7", l_irq_n, 0);
      chk(l_rdata == 8'h44, "R7", l_rdata, 8'h44); idle();
      lrd(10'h3FE); step(); idle();
      chk(l_irq_n, "R4", l_irq_n, 1);

      // R10: set and clear together
      rwr(10'h3FE, 8'h66); lrd(10'h3FE); step();
      chk(!l_irq_n, "R10", l_irq_n, 0); idle();
      lrd(10'h3FE); step(); idle();

      // R11: same-address collision
      lwr(10'h020, 8'hAA); rwr(10'h020, 8'h55); step(); idle();
      rrd(10'h020); step();
      chk(r_rdata == 8'hAA, "R11", r_rdata, 8'hAA); idle();

      // R12: read against other port's write
      lwr(10'h040, 8'h99); rrd(10'h040); step();
      chk(r_rdata == 8'h12 && r_rvalid, "R12", r_rdata, 8'h12); idle();
      rrd(10'h040); step();
      chk(r_rdata == 8'h99, "R12", r_rdata, 8'h99); idle();
      step();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule